// File: doc/BRIEF.md
# Tiled Multi-Dimensional Address Generator

This block produces the ordered stream of linear element addresses that a DMA engine needs in order to read a buffer of up to four dimensions as a sequence of tiles. A configuration applied at the block's inputs describes the buffer. It gives the buffer size and tile size per dimension, a signed start offset per dimension, a per-dimension boundary extent, and up to `NLOOP` traversal loops. Each traversal loop names the dimension it moves along, a stride in elements and a wrap count. The configuration is captured when a start pulse is accepted.

Every element of a tile is emitted with dimension 0 running fastest. The traversal loops then move the tile origin, with loop 0 as the innermost loop. Any element whose coordinate falls outside the boundary box is still emitted as a beat, but it carries a zero-fill flag so that the reader substitutes zero for the memory data. This covers coordinates that are reached through negative offsets. Beats leave through a registered valid/ready interface at one per cycle. The final beat is flagged, and a one-cycle done pulse follows its acceptance. A configuration that breaks the alignment or sizing rules is refused with a one-cycle error pulse, and no transfer starts.

Top module: `tile_addr_gen`

## Requirements
- R1: The emitted address is the sum over all dimensions of coordinate times pitch. The pitch of dimension 0 is 1, and the pitch of dimension d is the product of buffer sizes 0..d-1, taken modulo 2^AW.
- R2: Within one tile position, all tile elements are emitted, with the dimension 0 index fastest, then dimension 1, and so on up to dimension NDIM-1.
- R3: Traversal loop k is field slot k of the loop inputs. Loop 0 is the innermost loop. Its dimension field holds the dimension index it moves along. Each step adds its stride to that dimension's origin. After `wrap` steps the loop returns to its start and the next loop advances. A wrap value of 0 acts as 1. Only loops 0..cfg_loop_count-1 are active, and the settings of the remaining slots have no effect.
- R4: An element whose coordinate in any dimension is below 0 or not below the boundary extent is emitted with out_zero=1 and out_addr=0.
- R5: Offsets in every dimension below NDIM-1 are two's complement and may be negative. This shifts tiles partly outside the buffer.
- R6: A start is refused if any of the following holds: buffer size or tile size along dimension 0 multiplied by ELEM_BITS is not a multiple of 32; any buffer or tile size is zero; the offset of dimension NDIM-1 is negative. A refused start makes cfg_err high for exactly the cycle after the start, and produces no beat and no done.
- R7: While out_valid is high and out_ready is low, out_valid, out_addr, out_zero and out_last hold their values.
- R8: With out_ready held high, the first beat is valid in the second cycle after the accepted start, and one beat is accepted per cycle. For N beats, done is seen N+1 cycles after the start edge.
- R9: out_last is set only on the final beat. done is high for exactly one cycle, in the cycle after that beat is accepted.
- R10: A start pulse that arrives while a transfer is in progress is ignored. The configuration inputs are sampled only when a start is accepted.
- R11: After reset, out_valid, done and cfg_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse |
| cfg_buf_dim | input | NDIM*CW | Buffer size per dimension, dimension d in bits [d*CW +: CW] |
| cfg_tile_dim | input | NDIM*CW | Tile size per dimension |
| cfg_offset | input | NDIM*CW | Signed start offset per dimension |
| cfg_bound | input | NDIM*CW | Boundary extent per dimension |
| cfg_loop_dim | input | NLOOP*LW | Dimension index of each traversal loop |
| cfg_loop_stride | input | NLOOP*CW | Stride of each traversal loop, in elements |
| cfg_loop_wrap | input | NLOOP*CW | Step count of each traversal loop |
| cfg_loop_count | input | NW | Number of active traversal loops |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | Beat present |
| out_addr | output | AW | Linear element address |
| out_zero | output | 1 | Replace read data by zero |
| out_last | output | 1 | Final beat of the transfer |
| done | output | 1 | One-cycle pulse after the final beat is accepted |
| cfg_err | output | 1 | One-cycle pulse for a refused configuration |

## Verification
The hardest situation to reach is a tile that straddles the boundary box on more than one side. In that case the coordinates combine a negative offset, an intra-tile index and a loop contribution from a loop that is not the innermost one. The stimulus builds this with a two-loop walk whose offsets are negative in both low dimensions. It also uses a reordered walk that steps the highest dimension first and runs past a shortened boundary in that dimension. Both are run under random backpressure, so that held beats coincide with zero-filled ones. A start with an illegal configuration is also issued in the middle of a running transfer, to show that it is neither captured nor reported.

// File: rtl/tag_pkg.sv
package tag_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
  localparam int unsigned WORD_BITS = 32;
endpackage

// File: rtl/tag_cfg_prep.sv
module tag_cfg_prep #(
  parameter int NDIM      = 4,
  parameter int CW        = 12,
  parameter int AW        = 32,
  parameter int ELEM_BITS = 16
) (
  input  logic        [CW-1:0] buf_dim  [NDIM],
  input  logic        [CW-1:0] tile_dim [NDIM],
  input  logic signed [CW-1:0] offset   [NDIM],
  output logic                 bad,
  output logic        [AW-1:0] pitch    [NDIM]
);
  localparam int ALIGN = (ELEM_BITS >= int'(tag_pkg::WORD_BITS)) ? 1 : int'(tag_pkg::WORD_BITS) / ELEM_BITS;
  localparam logic [CW-1:0] AMASK = CW'(ALIGN - 1);

  always_comb begin
    bad = ((buf_dim[0] & AMASK) != '0) || ((tile_dim[0] & AMASK) != '0) || offset[NDIM-1][CW-1];
    for (int d = 0; d < NDIM; d++) begin
      if (buf_dim[d] == '0 || tile_dim[d] == '0) bad = 1'b1;
    end
    pitch[0] = AW'(1);
    for (int d = 1; d < NDIM; d++) begin
      pitch[d] = pitch[d-1] * AW'(buf_dim[d-1]);
    end
  end
endmodule

// File: rtl/tag_walk.sv
module tag_walk #(
  parameter int NDIM  = 4,
  parameter int NLOOP = 4,
  parameter int CW    = 12,
  parameter int NW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] tile_dim [NDIM],
  input  logic [CW-1:0] wrap     [NLOOP],
  input  logic [NW-1:0] nloops,
  output logic [CW-1:0] ecnt     [NDIM],
  output logic [CW-1:0] lcnt     [NLOOP],
  output logic          at_end
);
  logic [CW-1:0] e_nx [NDIM];
  logic [CW-1:0] l_nx [NLOOP];

  always_comb begin
    logic c;
    logic full;
    logic [CW-1:0] wl;
    c      = step;
    at_end = 1'b1;
    for (int d = 0; d < NDIM; d++) begin
      full    = (ecnt[d] == tile_dim[d] - CW'(1));
      e_nx[d] = !c ? ecnt[d] : (full ? '0 : ecnt[d] + CW'(1));
      c       = c & full;
      at_end  = at_end & full;
    end
    for (int k = 0; k < NLOOP; k++) begin
      wl      = (wrap[k] == '0) ? CW'(1) : wrap[k];
      full    = (NW'(k) >= nloops) || (lcnt[k] == wl - CW'(1));
      l_nx[k] = !c ? lcnt[k] : (full ? '0 : lcnt[k] + CW'(1));
      c       = c & full;
      at_end  = at_end & full;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int d = 0; d < NDIM; d++) ecnt[d] <= '0;
      for (int k = 0; k < NLOOP; k++) lcnt[k] <= '0;
    end else begin
      ecnt <= e_nx;
      lcnt <= l_nx;
    end
  end
endmodule

// File: rtl/tag_addr_calc.sv
module tag_addr_calc #(
  parameter int NDIM  = 4,
  parameter int NLOOP = 4,
  parameter int CW    = 12,
  parameter int AW    = 32,
  parameter int LW    = 2,
  parameter int NW    = 3
) (
  input  logic        [CW-1:0] offset   [NDIM],
  input  logic        [CW-1:0] bound    [NDIM],
  input  logic        [AW-1:0] pitch    [NDIM],
  input  logic        [LW-1:0] loop_dim [NLOOP],
  input  logic        [CW-1:0] stride   [NLOOP],
  input  logic        [NW-1:0] nloops,
  input  logic        [CW-1:0] ecnt     [NDIM],
  input  logic        [CW-1:0] lcnt     [NLOOP],
  output logic        [AW-1:0] addr,
  output logic                 zero
);
  localparam int SW = 2 * CW + 4;

  logic signed [SW-1:0] crd [NDIM];

  always_comb begin
    logic [2*CW-1:0] prod;
    logic [AW-1:0] acc;
    for (int d = 0; d < NDIM; d++) begin
      crd[d] = SW'($signed(offset[d])) + SW'(ecnt[d]);
    end
    for (int k = 0; k < NLOOP; k++) begin
      prod = (2*CW)'(lcnt[k]) * (2*CW)'(stride[k]);
      for (int d = 0; d < NDIM; d++) begin
        if (NW'(k) < nloops && loop_dim[k] == LW'(d)) crd[d] = crd[d] + SW'(prod);
      end
    end
    zero = 1'b0;
    acc  = '0;
    for (int d = 0; d < NDIM; d++) begin
      if (crd[d][SW-1] || (crd[d] >= $signed(SW'(bound[d])))) zero = 1'b1;
      acc = acc + AW'(crd[d][CW-1:0]) * pitch[d];
    end
    addr = zero ? '0 : acc;
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter  int NDIM      = 4,
  parameter  int NLOOP     = 4,
  parameter  int CW        = 12,
  parameter  int AW        = 32,
  parameter  int ELEM_BITS = 16,
  localparam int LW        = $clog2(NDIM),
  localparam int NW        = $clog2(NLOOP + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NDIM*CW-1:0]  cfg_buf_dim,
  input  logic [NDIM*CW-1:0]  cfg_tile_dim,
  input  logic [NDIM*CW-1:0]  cfg_offset,
  input  logic [NDIM*CW-1:0]  cfg_bound,
  input  logic [NLOOP*LW-1:0] cfg_loop_dim,
  input  logic [NLOOP*CW-1:0] cfg_loop_stride,
  input  logic [NLOOP*CW-1:0] cfg_loop_wrap,
  input  logic [NW-1:0]       cfg_loop_count,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [AW-1:0]       out_addr,
  output logic                out_zero,
  output logic                out_last,
  output logic                done,
  output logic                cfg_err
);
  import tag_pkg::*;

  logic        [CW-1:0] in_buf  [NDIM];
  logic        [CW-1:0] in_tile [NDIM];
  logic signed [CW-1:0] in_off  [NDIM];
  logic        [CW-1:0] in_bnd  [NDIM];
  logic        [LW-1:0] in_ldim [NLOOP];
  logic        [CW-1:0] in_lstr [NLOOP];
  logic        [CW-1:0] in_lwr  [NLOOP];

  always_comb begin
    for (int d = 0; d < NDIM; d++) begin
      in_buf[d]  = cfg_buf_dim[d*CW +: CW];
      in_tile[d] = cfg_tile_dim[d*CW +: CW];
      in_off[d]  = cfg_offset[d*CW +: CW];
      in_bnd[d]  = cfg_bound[d*CW +: CW];
    end
    for (int k = 0; k < NLOOP; k++) begin
      in_ldim[k] = cfg_loop_dim[k*LW +: LW];
      in_lstr[k] = cfg_loop_stride[k*CW +: CW];
      in_lwr[k]  = cfg_loop_wrap[k*CW +: CW];
    end
  end

  logic          bad;
  logic [AW-1:0] in_pitch [NDIM];

  tag_cfg_prep #(.NDIM(NDIM), .CW(CW), .AW(AW), .ELEM_BITS(ELEM_BITS)) u_prep (
    .buf_dim(in_buf), .tile_dim(in_tile), .offset(in_off), .bad(bad), .pitch(in_pitch)
  );

  // Captured configuration
  logic [CW-1:0] tile_q  [NDIM];
  logic [CW-1:0] off_q   [NDIM];
  logic [CW-1:0] bnd_q   [NDIM];
  logic [AW-1:0] pitch_q [NDIM];
  logic [LW-1:0] ldim_q  [NLOOP];
  logic [CW-1:0] lstr_q  [NLOOP];
  logic [CW-1:0] lwr_q   [NLOOP];
  logic [NW-1:0] nl_q;

  run_state_e st_q;
  logic       busy, go, load, adv, at_end, calc_zero, last_q;
  logic [AW-1:0] calc_addr;
  logic [CW-1:0] ecnt [NDIM];
  logic [CW-1:0] lcnt [NLOOP];

  assign busy = (st_q == ST_RUN) || out_valid;
  assign go   = start && !busy;
  assign load = go && !bad;
  assign adv  = (st_q == ST_RUN) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (load) begin
      tile_q  <= in_tile;
      bnd_q   <= in_bnd;
      pitch_q <= in_pitch;
      ldim_q  <= in_ldim;
      lstr_q  <= in_lstr;
      lwr_q   <= in_lwr;
      nl_q    <= cfg_loop_count;
      for (int d = 0; d < NDIM; d++) off_q[d] <= in_off[d];
    end
  end

  tag_walk #(.NDIM(NDIM), .NLOOP(NLOOP), .CW(CW), .NW(NW)) u_walk (
    .clk(clk), .rst(rst), .clear(load), .step(adv),
    .tile_dim(tile_q), .wrap(lwr_q), .nloops(nl_q),
    .ecnt(ecnt), .lcnt(lcnt), .at_end(at_end)
  );

  tag_addr_calc #(.NDIM(NDIM), .NLOOP(NLOOP), .CW(CW), .AW(AW), .LW(LW), .NW(NW)) u_calc (
    .offset(off_q), .bound(bnd_q), .pitch(pitch_q), .loop_dim(ldim_q), .stride(lstr_q),
    .nloops(nl_q), .ecnt(ecnt), .lcnt(lcnt), .addr(calc_addr), .zero(calc_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_zero  <= 1'b0;
      last_q    <= 1'b0;
      done      <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      done    <= out_valid && out_ready && last_q;
      cfg_err <= go && bad;
      if (load) st_q <= ST_RUN;
      if (adv) begin
        out_valid <= 1'b1;
        out_addr  <= calc_addr;
        out_zero  <= calc_zero;
        last_q    <= at_end;
        if (at_end) st_q <= ST_IDLE;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_last = last_q;
endmodule

// File: rtl/tag_checker.sv
module tag_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_zero,
  input logic          out_last,
  input logic          done,
  input logic          cfg_err
);
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_zero) && $stable(out_last));

  a_r9_done_follows_last: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> done);

  a_r9_done_has_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready && out_last));

  a_r4_zero_addr: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_zero |-> out_addr == '0);

  a_r6_err_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !out_valid && $past(start));

  a_r11_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> !out_valid && !done && !cfg_err);
endmodule

bind tile_addr_gen tag_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_zero(out_zero), .out_last(out_last), .done(done), .cfg_err(cfg_err)
);

// File: tb/tile_addr_gen_bench.sv
`timescale 1ns/1ps
module tile_addr_gen_bench;
  localparam int NDIM = 4, NLOOP = 4, CW = 12, AW = 32, LW = 2, NW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NDIM*CW-1:0]  cfg_buf_dim, cfg_tile_dim, cfg_offset, cfg_bound;
  logic [NLOOP*LW-1:0] cfg_loop_dim;
  logic [NLOOP*CW-1:0] cfg_loop_stride, cfg_loop_wrap;
  logic [NW-1:0]       cfg_loop_count;
  logic out_ready = 1'b1;
  logic out_valid, out_zero, out_last, done, cfg_err;
  logic [AW-1:0] out_addr;

  always #2 clk = ~clk;

  tile_addr_gen u_tile_addr_gen (
    .clk(clk), .rst(rst), .start(start), .cfg_buf_dim(cfg_buf_dim), .cfg_tile_dim(cfg_tile_dim),
    .cfg_offset(cfg_offset), .cfg_bound(cfg_bound), .cfg_loop_dim(cfg_loop_dim),
    .cfg_loop_stride(cfg_loop_stride), .cfg_loop_wrap(cfg_loop_wrap), .cfg_loop_count(cfg_loop_count),
    .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr), .out_zero(out_zero),
    .out_last(out_last), .done(done), .cfg_err(cfg_err)
  );

  typedef struct { int addr; bit z; bit last; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  int done_cnt = 0, err_cnt = 0;
  bit rnd = 1'b0;
  int bd[4], td[4], off[4], bnd[4], ld[4], ls[4], lw[4], nl;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int d = 0; d < NDIM; d++) begin
      cfg_buf_dim[d*CW +: CW]  = CW'(bd[d]);
      cfg_tile_dim[d*CW +: CW] = CW'(td[d]);
      cfg_offset[d*CW +: CW]   = CW'(off[d]);
      cfg_bound[d*CW +: CW]    = CW'(bnd[d]);
    end
    for (int k = 0; k < NLOOP; k++) begin
      cfg_loop_dim[k*LW +: LW]    = LW'(ld[k]);
      cfg_loop_stride[k*CW +: CW] = CW'(ls[k]);
      cfg_loop_wrap[k*CW +: CW]   = CW'(lw[k]);
    end
    cfg_loop_count = NW'(nl);
  endtask

  // Nested-loop reference: outer traversal loops, inner tile scan, dim 0 fastest
  task automatic build_expect(output int n);
    int w[4], p[4], a[4], e[4];
    exp_t t;
    n = 0;
    for (int k = 0; k < 4; k++) w[k] = (k < nl) ? ((lw[k] == 0) ? 1 : lw[k]) : 1;
    p[0] = 1;
    for (int d = 1; d < 4; d++) p[d] = p[d-1] * bd[d-1];
    for (int a3 = 0; a3 < w[3]; a3++) for (int a2 = 0; a2 < w[2]; a2++)
    for (int a1 = 0; a1 < w[1]; a1++) for (int a0 = 0; a0 < w[0]; a0++)
    for (int e3 = 0; e3 < td[3]; e3++) for (int e2 = 0; e2 < td[2]; e2++)
    for (int e1 = 0; e1 < td[1]; e1++) for (int e0 = 0; e0 < td[0]; e0++) begin
      bit z;
      int ad;
      a = '{a0, a1, a2, a3};
      e = '{e0, e1, e2, e3};
      z = 1'b0;
      ad = 0;
      for (int d = 0; d < 4; d++) begin
        int c;
        c = off[d] + e[d];
        for (int k = 0; k < 4; k++) if (k < nl && ld[k] == d) c += a[k] * ls[k];
        if (c < 0 || c >= bnd[d]) z = 1'b1;
        ad += c * p[d];
      end
      t.addr = z ? 0 : ad;
      t.z = z;
      t.last = 1'b0;
      q.push_back(t);
      n++;
    end
    t = q.pop_back();
    t.last = 1'b1;
    q.push_back(t);
  endtask

  // Monitor / scoreboard
  bit hold_pend = 1'b0;
  logic [AW-1:0] h_addr;
  logic h_zero, h_last;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        chk(out_valid && out_addr == h_addr && out_zero == h_zero && out_last == h_last,
            "R7 beat held under backpressure", longint'(out_addr), longint'(h_addr));
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected beat", longint'(out_addr), -1);
        end else begin
          exp_t t;
          t = q.pop_front();
          chk(out_addr == 32'(t.addr), "R1 R2 R3 R5 address", longint'(out_addr), t.addr);
          chk(out_zero == t.z, "R4 zero flag", out_zero, t.z);
          chk(out_last == t.last, "R9 last flag", out_last, t.last);
        end
      end
      hold_pend = out_valid && !out_ready;
      h_addr = out_addr;
      h_zero = out_zero;
      h_last = out_last;
      if (done) done_cnt++;
      if (cfg_err) err_cnt++;
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = rnd ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_cfg(input bit rnd_r, input int exp_n, input string tag);
    int n, cyc;
    apply_cfg();
    build_expect(n);
    chk(n == exp_n, {tag, " R3 model beat count"}, n, exp_n);
    rnd = rnd_r;
    done_cnt = 0;
    err_cnt = 0;
    pulse_start();
    cyc = 0;
    while (!done) begin
      @(posedge clk); #1;
      cyc++;
    end
    if (!rnd_r) chk(cyc == exp_n + 1, {tag, " R8 cycles to done"}, cyc, exp_n + 1);
    rnd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(q.size() == 0, {tag, " R2 all beats emitted"}, q.size(), 0);
    chk(done_cnt == 1, {tag, " R9 single done pulse"}, done_cnt, 1);
    chk(err_cnt == 0, {tag, " R6 no error"}, err_cnt, 0);
  endtask

  task automatic err_case(input string tag);
    apply_cfg();
    done_cnt = 0;
    err_cnt = 0;
    pulse_start();
    chk(cfg_err == 1'b1, {tag, " R6 error in cycle after start"}, cfg_err, 1);
    repeat (4) @(posedge clk);
    #1;
    chk(err_cnt == 1, {tag, " R6 one error pulse"}, err_cnt, 1);
    chk(done_cnt == 0, {tag, " R6 no done"}, done_cnt, 0);
    chk(!out_valid && q.size() == 0, {tag, " R6 no beats"}, out_valid, 0);
  endtask

  task automatic cfg_c1();
    bd = '{8, 4, 2, 1}; td = '{4, 2, 1, 1}; off = '{0, 0, 0, 0}; bnd = '{8, 4, 2, 1};
    ld = '{0, 1, 2, 0}; ls = '{4, 2, 1, 0}; lw = '{2, 2, 2, 0}; nl = 3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cfg_c1();
    apply_cfg();
    repeat (5) @(posedge clk);
    #1;
    chk(!out_valid && !done && !cfg_err, "R11 reset outputs low", out_valid, 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(!out_valid && !done && !cfg_err, "R11 idle after reset", out_valid, 0);

    // C1: plain three-loop walk, full throughput
    cfg_c1();
    run_cfg(1'b0, 64, "C1");

    // R10: illegal start mid-transfer must be ignored
    cfg_c1();
    apply_cfg();
    build_expect(n);
    done_cnt = 0;
    err_cnt = 0;
    pulse_start();
    repeat (4) @(posedge clk);
    #1;
    bd[0] = 7;
    apply_cfg();
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    while (!done) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(err_cnt == 0, "R10 busy start not reported", err_cnt, 0);
    chk(done_cnt == 1 && q.size() == 0, "R10 stream unchanged by busy start", q.size(), 0);

    // C2: negative offsets in two dims, zero fill on both sides, backpressure
    bd = '{8, 6, 1, 1}; td = '{4, 3, 1, 1}; off = '{-2, -1, 0, 0}; bnd = '{8, 6, 1, 1};
    ld = '{0, 1, 3, 2}; ls = '{4, 3, 1, 1}; lw = '{3, 2, 7, 7}; nl = 2;
    run_cfg(1'b1, 72, "C2");

    // C3: highest dimension stepped first, shortened boundary in dim 3
    bd = '{4, 2, 2, 3}; td = '{2, 2, 1, 1}; off = '{0, 0, 0, 0}; bnd = '{4, 2, 2, 2};
    ld = '{3, 2, 0, 1}; ls = '{1, 1, 2, 1}; lw = '{3, 2, 2, 0}; nl = 3;
    run_cfg(1'b1, 48, "C3");

    // C4: wrap 0 acts as 1, inactive loop slot ignored
    bd = '{4, 2, 1, 1}; td = '{2, 1, 1, 1}; off = '{0, 0, 0, 0}; bnd = '{4, 2, 1, 1};
    ld = '{1, 0, 0, 0}; ls = '{1, 1, 0, 0}; lw = '{0, 5, 0, 0}; nl = 1;
    run_cfg(1'b0, 2, "C4");

    // R6 refusals
    cfg_c1(); bd[0] = 7;  err_case("E1 odd buffer dim0");
    cfg_c1(); td[0] = 3;  err_case("E2 odd tile dim0");
    cfg_c1(); off[3] = -1; err_case("E3 negative top offset");
    cfg_c1(); td[2] = 0;  err_case("E4 zero tile size");

    // legal run still works after refusals
    cfg_c1();
    run_cfg(1'b0, 64, "C1b");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule